// File: doc/BRIEF.md
# Wait-State Bus Target

This block is a register target that sits on a shared parallel I/O bus, the kind with an address, an address-valid qualifier, active-low read and write strobes, and a wired channel-ready line. It watches every bus cycle. When a cycle falls inside its small address window and a command is active, it claims the cycle and holds the channel-ready line low. That low level stretches the master's cycle for a fixed, parameter-set number of clock cycles. It then lets the line go so the master can finish.

Channel-ready is modelled as a value with a separate drive enable. The enable is on only while the target is holding the line low, so an idle target never pulls the shared line down. At the moment it releases ready, the target either stores the write data into the addressed register or loads the addressed register onto its read-data output. Read data then stays stable and enabled until the master lets the command go high. A cycle is only claimed when its command begins from an idle bus. A command that stays low, or that starts while the address is somewhere else, is therefore never claimed a second time or partway through.

Top module: `bus_wait_target`

## Requirements
- R1: During and directly after reset, `rdy` is 1, `rdy_oe` is 0, `rdata_oe` is 0, and all registers hold 0.
- R2: A cycle is claimed at a clock edge when all of the following hold: `addr_valid` is 1; `bus_addr` lies in BASE to BASE+NREGS-1; `rd_n` or `wr_n` is 0; and both commands were 1 at the previous edge. After that edge, `rdy_oe` is 1 and `rdy` is 0.
- R3: Once claimed, `rdy` stays low (with `rdy_oe` 1) for exactly WAIT_CYCLES clock cycles, then `rdy_oe` returns to 0 and `rdy` to 1.
- R4: With WAIT_CYCLES = 0, `rdy_oe` is never 1, and the access completes at the edge where the cycle is claimed.
- R5: A cycle with `addr_valid` 0 or an address outside the window gets no response: no ready drive, no read-data enable, and no register change.
- R6: A write (`wr_n` 0, `rd_n` 1) stores `wdata` into register `bus_addr[IDX_W-1:0]`, sampled at the releasing edge. A later read of that register returns the stored value. When both strobes are low, the cycle is treated as a read.
- R7: For a read, `rdata_oe` is 1 from the releasing edge until the edge where the command is seen high. `rdata` holds the register value unchanged for that whole interval.
- R8: No new cycle is claimed until both commands have been seen high. This holds even if the address moves to a different in-window register while the command stays low, and when a command that began outside the window later gets an in-window address.
- R9: If both commands return high while ready is held low, the target releases ready at the next edge and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| addr_valid | input | 1 | Address qualifier, 1 when `bus_addr` is meaningful |
| rd_n | input | 1 | Read command, active low |
| wr_n | input | 1 | Write command, active low |
| wdata | input | DATA_W | Write data from the master |
| rdata | output | DATA_W | Read data to the master |
| rdata_oe | output | 1 | Read-data drive enable |
| rdy | output | 1 | Channel-ready value, 1 = ready |
| rdy_oe | output | 1 | Channel-ready drive enable, 1 only while pulling ready low |

## Verification
The assertions assume the following about the inputs: they are synchronous to `clk`; the master keeps the address and write data steady while a claimed command is low; and each cycle starts from a clock where both commands are high. The stimulus keeps to these rules by driving every input on the falling edge and holding each access for a fixed number of clocks. It also inserts an idle clock between accesses. The only deliberate departures are the withdrawn-command case and the held-command, moving-address cases. Both of these are requirements in their own right, and the properties that cover them make no assumption about address stability.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_HOLD = 2'd2
   } bwt_state_e;

   function automatic int unsigned bwt_cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/bwt_decode.sv
module bwt_decode #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned IDX_W  = 2,
   parameter logic [ADDR_W-1:0] BASE = '0
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              addr_valid,
   output logic              in_window,
   output logic [IDX_W-1:0]  idx
);

   localparam int unsigned TAG_W = ADDR_W - IDX_W;
   localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:IDX_W];

   if (IDX_W >= ADDR_W) begin : g_bad_width
      $error("bwt_decode: index width must be below address width");
   end
   if (BASE[IDX_W-1:0] != '0) begin : g_bad_base
      $error("bwt_decode: BASE must be aligned to the register count");
   end

   assign in_window = addr_valid && (bus_addr[ADDR_W-1:IDX_W] == BASE_TAG);
   assign idx       = bus_addr[IDX_W-1:0];

endmodule

// File: rtl/bwt_wait_ctrl.sv
module bwt_wait_ctrl
   import bwt_pkg::*;
#(
   parameter int unsigned WAIT_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_window,
   input  logic cmd_active,
   output logic accept,
   output logic complete,
   output logic waiting,
   output logic holding
);

   localparam int unsigned CNT_W = bwt_cnt_w(WAIT_CYCLES);

   bwt_state_e state_q, state_d;
   logic       armed_q;

   // A claim needs a command that started from an idle bus.
   assign accept = (state_q == ST_IDLE) && armed_q && in_window && cmd_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         state_q <= ST_IDLE;
      end else begin
         armed_q <= !cmd_active;
         state_q <= state_d;
      end
   end

   if (WAIT_CYCLES == 0) begin : g_no_wait
      assign complete = accept;

      always_comb begin
         state_d = state_q;
         unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_HOLD;
            ST_HOLD: if (!cmd_active) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
         endcase
      end
   end else begin : g_wait
      logic [CNT_W-1:0] cnt_q;
      logic             last;

      assign last     = (cnt_q == CNT_W'(1));
      assign complete = (state_q == ST_WAIT) && cmd_active && last;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (accept) begin
            cnt_q <= CNT_W'(WAIT_CYCLES);
         end else if (state_q == ST_WAIT && !last) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end

      always_comb begin
         state_d = state_q;
         unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_WAIT;
            ST_WAIT: begin
               if (!cmd_active)   state_d = ST_IDLE;
               else if (complete) state_d = ST_HOLD;
            end
            ST_HOLD: if (!cmd_active) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
         endcase
      end
   end

   assign waiting = (state_q == ST_WAIT);
   assign holding = (state_q == ST_HOLD);

endmodule

// File: rtl/bwt_regfile.sv
module bwt_regfile #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NREGS  = 4,
   parameter int unsigned IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] regs [NREGS];
   logic [DATA_W-1:0] rdata_q;

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[g] <= '0;
         end else if (wr_en && idx == IDX_W'(g)) begin
            regs[g] <= wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_en) begin
         rdata_q <= regs[idx];
      end
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/bus_wait_target.sv
module bus_wait_target #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned NREGS       = 4,
   parameter logic [ADDR_W-1:0] BASE  = 16'h0300,
   parameter int unsigned WAIT_CYCLES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              addr_valid,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe,
   output logic              rdy,
   output logic              rdy_oe
);

   localparam int unsigned IDX_W = (NREGS < 2) ? 1 : $clog2(NREGS);

   if ((1 << IDX_W) != NREGS) begin : g_bad_nregs
      $error("bus_wait_target: NREGS must be a power of two, at least 2");
   end

   logic             in_window;
   logic [IDX_W-1:0] dec_idx;
   logic             cmd_active;
   logic             accept, complete, waiting, holding;
   logic [IDX_W-1:0] idx_q, op_idx;
   logic             is_rd_q, op_rd;

   assign cmd_active = !rd_n || !wr_n;

   bwt_decode #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .BASE   (BASE)
   ) u_decode (
      .bus_addr   (bus_addr),
      .addr_valid (addr_valid),
      .in_window  (in_window),
      .idx        (dec_idx)
   );

   bwt_wait_ctrl #(
      .WAIT_CYCLES (WAIT_CYCLES)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_window  (in_window),
      .cmd_active (cmd_active),
      .accept     (accept),
      .complete   (complete),
      .waiting    (waiting),
      .holding    (holding)
   );

   // Operation attributes are frozen at the claim.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         is_rd_q <= 1'b0;
      end else if (accept) begin
         idx_q   <= dec_idx;
         is_rd_q <= !rd_n;
      end
   end

   // With no wait states the claim and completion share one edge.
   assign op_idx = accept ? dec_idx : idx_q;
   assign op_rd  = accept ? !rd_n   : is_rd_q;

   bwt_regfile #(
      .DATA_W (DATA_W),
      .NREGS  (NREGS),
      .IDX_W  (IDX_W)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (complete && !op_rd),
      .rd_en (complete && op_rd),
      .idx   (op_idx),
      .wdata (wdata),
      .rdata (rdata)
   );

   assign rdy_oe   = waiting;
   assign rdy      = !waiting;
   assign rdata_oe = holding && is_rd_q;

endmodule

// File: rtl/bwt_checker.sv
module bwt_checker #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned NREGS       = 4,
   parameter logic [ADDR_W-1:0] BASE  = 16'h0300,
   parameter int unsigned WAIT_CYCLES = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              addr_valid,
   input logic              rd_n,
   input logic              wr_n,
   input logic [DATA_W-1:0] rdata,
   input logic              rdata_oe,
   input logic              rdy,
   input logic              rdy_oe
);

   logic       hit_now;
   int unsigned low_run;
   logic [1:0] since;

   assign hit_now = addr_valid && (bus_addr >= BASE)
                    && (bus_addr < BASE + ADDR_W'(NREGS)) && (!rd_n || !wr_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run <= 0;
         since   <= '0;
      end else begin
         low_run <= rdy_oe ? low_run + 1 : 0;
         if (since != 2'd3) since <= since + 2'd1;
      end
   end

   // R1
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_oe |-> rdy);

   // R2
   claim_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_oe) |-> $past(hit_now));

   // R3
   wait_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= WAIT_CYCLES);

   // R4
   if (WAIT_CYCLES == 0) begin : g_zero
      no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !rdy_oe);
   end

   // R7
   rdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_oe && $past(rdata_oe)) |-> $stable(rdata));

   // R7
   rdata_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> $past(!rd_n));

   // R8
   claim_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rdy_oe) && since >= 2'd2) |-> $past(rd_n && wr_n, 2));

   // R9
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_oe && rd_n && wr_n) |=> !rdy_oe);

endmodule

bind bus_wait_target bwt_checker #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .NREGS       (NREGS),
   .BASE        (BASE),
   .WAIT_CYCLES (WAIT_CYCLES)
) u_bwt_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .addr_valid (addr_valid),
   .rd_n       (rd_n),
   .wr_n       (wr_n),
   .rdata      (rdata),
   .rdata_oe   (rdata_oe),
   .rdy        (rdy),
   .rdy_oe     (rdy_oe)
);

// File: tb/test_bus_wait_target.sv
module test_bus_wait_target;

   localparam int WAITS [2] = '{3, 0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        addr_valid = 1'b0;
   logic        rd_n = 1'b1, wr_n = 1'b1;
   logic [7:0]  wdata = '0;

   logic [7:0]  rdata [2];
   logic        rdata_oe [2], rdy [2], rdy_oe [2];

   int checks = 0, failures = 0, cycles = 0;
   string phase = "R1";

   // reference state
   int wl [2], held [2], armed [2], isrd [2], idx [2], rv [2];
   int mem [2][4];

   always #2 clk = ~clk;

   bus_wait_target i_bus_wait_target (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .addr_valid(addr_valid),
      .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .rdata(rdata[0]),
      .rdata_oe(rdata_oe[0]), .rdy(rdy[0]), .rdy_oe(rdy_oe[0]));

   bus_wait_target #(.WAIT_CYCLES(0)) i_bus_wait_target_nw (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .addr_valid(addr_valid),
      .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .rdata(rdata[1]),
      .rdata_oe(rdata_oe[1]), .rdy(rdy[1]), .rdy_oe(rdy_oe[1]));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s/%s t=%0t actual=%0h expected=%0h", phase, tag, $time, act, exp);
      end
   endtask

   task automatic finish_ref(input int k);
      held[k] = 1;
      if (isrd[k] != 0) rv[k] = mem[k][idx[k]];
      else mem[k][idx[k]] = int'(wdata);
   endtask

   always @(posedge clk) begin
      cycles++;
      for (int k = 0; k < 2; k++) begin
         if (!rst_n) begin
            wl[k] = 0; held[k] = 0; armed[k] = 1; isrd[k] = 0; idx[k] = 0; rv[k] = 0;
            for (int j = 0; j < 4; j++) mem[k][j] = 0;
         end else begin
            int cmd, hit;
            cmd = (!rd_n || !wr_n) ? 1 : 0;
            hit = (addr_valid && bus_addr[15:2] == 14'h00C0 && cmd != 0) ? 1 : 0;
            if (wl[k] > 0) begin
               if (cmd == 0) wl[k] = 0;
               else if (wl[k] == 1) begin wl[k] = 0; finish_ref(k); end
               else wl[k]--;
            end else if (held[k] != 0) begin
               if (cmd == 0) held[k] = 0;
            end else if (armed[k] != 0 && hit != 0) begin
               idx[k]  = int'(bus_addr[1:0]);
               isrd[k] = rd_n ? 0 : 1;
               if (WAITS[k] == 0) finish_ref(k);
               else wl[k] = WAITS[k];
            end
            armed[k] = (cmd == 0) ? 1 : 0;
         end
      end
      #1;
      for (int k = 0; k < 2; k++) begin
         chk(k == 0 ? "R2_rdy_oe" : "R4_rdy_oe", int'(rdy_oe[k]), wl[k] > 0 ? 1 : 0);
         chk("R3_rdy", int'(rdy[k]), wl[k] > 0 ? 0 : 1);
         chk("R7_rdata_oe", int'(rdata_oe[k]), (held[k] != 0 && isrd[k] != 0) ? 1 : 0);
         if (rdata_oe[k]) chk("R6_rdata", int'(rdata[k]), rv[k]);
      end
      if (cycles > 100000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // one access: drive at a falling edge, hold the command for n clocks
   task automatic access(input logic [15:0] a, input logic v, input logic rd,
                         input logic [7:0] d, input int n);
      @(negedge clk);
      bus_addr = a; addr_valid = v; wdata = d;
      if (rd) rd_n = 1'b0; else wr_n = 1'b0;
      repeat (n) @(negedge clk);
      rd_n = 1'b1; wr_n = 1'b1; addr_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values observed while in reset
      for (int k = 0; k < 2; k++) begin
         chk("R1_rdy", int'(rdy[k]), 1);
         chk("R1_rdy_oe", int'(rdy_oe[k]), 0);
         chk("R1_rdata_oe", int'(rdata_oe[k]), 0);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      phase = "R1";
      access(16'h0302, 1'b1, 1'b1, 8'h00, 6);   // fresh register reads 0

      phase = "R6";
      access(16'h0301, 1'b1, 1'b0, 8'hA5, 6);
      access(16'h0303, 1'b1, 1'b0, 8'h3C, 6);
      access(16'h0300, 1'b1, 1'b0, 8'hFF, 5);
      access(16'h0301, 1'b1, 1'b1, 8'h00, 6);
      access(16'h0303, 1'b1, 1'b1, 8'h00, 7);
      access(16'h0300, 1'b1, 1'b1, 8'h00, 5);

      phase = "R5";
      access(16'h0311, 1'b1, 1'b0, 8'h11, 6);
      access(16'h0302, 1'b0, 1'b0, 8'h22, 6);
      access(16'h0301, 1'b1, 1'b1, 8'h00, 6);   // still A5
      access(16'h0302, 1'b1, 1'b1, 8'h00, 6);   // still 0

      phase = "R9";
      access(16'h0302, 1'b1, 1'b0, 8'h77, 2);   // withdrawn mid-wait
      access(16'h0302, 1'b1, 1'b1, 8'h00, 6);   // main instance still 0

      phase = "R8";
      @(negedge clk);
      bus_addr = 16'h0301; addr_valid = 1'b1; rd_n = 1'b0;
      repeat (6) @(negedge clk);
      bus_addr = 16'h0303;                      // moved, command held low
      repeat (6) @(negedge clk);
      rd_n = 1'b1; addr_valid = 1'b0;
      @(negedge clk);
      bus_addr = 16'h0400; addr_valid = 1'b1; wr_n = 1'b0; wdata = 8'h5A;
      repeat (2) @(negedge clk);
      bus_addr = 16'h0302;                      // entered window mid-command
      repeat (6) @(negedge clk);
      wr_n = 1'b1; addr_valid = 1'b0;
      @(negedge clk);
      access(16'h0302, 1'b1, 1'b1, 8'h00, 6);

      phase = "R4";
      access(16'h0302, 1'b1, 1'b0, 8'hC3, 1);
      access(16'h0302, 1'b1, 1'b1, 8'h00, 2);

      phase = "R7";
      access(16'h0303, 1'b1, 1'b1, 8'h00, 12);

      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule